// File: doc/BRIEF.md
# Quadrature Position Extender

This block turns a two-channel quadrature encoder into a 32-bit signed absolute position for a sampled servo loop. The two encoder channels are synchronized, decoded at four counts per slot cycle into a free-running 16-bit up/down counter, and left to run between samples. On a sample request the block fetches that counter over an internal byte-wide lane, high byte first. The fetch of the high byte freezes the whole count, so the low byte that follows belongs to the same instant.

The fresh 16-bit reading is subtracted from the reading stored at the previous sample. The 16-bit difference is sign-extended and added to the running 32-bit position. Because only the difference is used, the position stays correct when the narrow counter wraps, in either direction, as long as the shaft moves fewer than 32768 counts between two samples. Each result carries the current position and the two positions before it, which a downstream velocity stage uses to form a difference across two sample periods.

The result leaves on a valid/ready stream. `pos_valid` rises with a new set of three positions and stays high, with all three values frozen, until `pos_ready` is seen high on a clock edge. A sample request is taken only when the block is idle. From the accepted request up to and including the handshake cycle, further requests are dropped and are not queued. Back-pressure therefore delays the next sample but never loses or overwrites one.

Top module: `qpos_extender`

## Requirements
- R1: After reset the counter, the stored previous reading, `pos_now`, `pos_prev1` and `pos_prev2` are all zero, and `pos_valid` and `quad_err` are low.
- R2: With the channel pair written {A,B}, the order 00→01→11→10→00 adds one count per transition and the reverse order subtracts one, which gives four counts per slot cycle. The counter changes by at most one per clock.
- R3: A change of both channels between two synchronized samples leaves the count unchanged and raises `quad_err` for one clock.
- R4: The count is fetched high byte first over an 8-bit lane. Fetching the high byte latches all 16 bits, and the low byte comes from that latch, so the reported position is always a value the counter actually held during the fetch.
- R5: `pos_now` becomes the previous position plus the sign-extended 16-bit difference (new reading minus previous reading). This keeps it correct across counter wrap below zero and past 0x7FFF and 0xFFFF.
- R6: With each new result, `pos_prev2` takes the old `pos_prev1` and `pos_prev1` takes the old `pos_now`.
- R7: While `pos_valid` is high and `pos_ready` is low, `pos_valid` stays high and all three positions stay stable.
- R8: A `sample_req` that arrives while a sample is being fetched or is waiting for its handshake has no effect and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| sample_req | input | 1 | One-clock request to take a sample |
| pos_ready | input | 1 | Downstream ready for the position stream |
| pos_valid | output | 1 | Position stream valid |
| pos_now | output | 32 | Position x(n) |
| pos_prev1 | output | 32 | Position x(n-1) |
| pos_prev2 | output | 32 | Position x(n-2) |
| quad_err | output | 1 | One-clock flag for an illegal channel transition |

## Verification
The bench drives the count below zero and then more than 32768 counts upward in two legal steps. A design that sign-extends the raw reading instead of the difference would then report a negative or shifted position. It starts samples at many offsets while the counter is rolling from 0xFFFF to 0x0000. A lane that reads a live low byte instead of the latched one would be off by 256 there. It makes a double-channel jump, which must neither count nor go unflagged. It holds `pos_ready` low and fires a second request into the busy window. A design that moved its outputs, or queued the request, would show changed values or an unexpected extra result.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_HOLD
  } fetch_state_e;

  // Map the channel pair {A,B} to its position in the 4-step cycle.
  function automatic logic [1:0] phase_of(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/quad_counter.sv
module quad_counter
  import qpos_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8,
  localparam int NB = CW / BW,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ab_sync,
  input  logic          rd_stb,
  input  logic [IW-1:0] rd_idx,
  output logic [BW-1:0] rd_byte,
  output logic          bad_step
);
  logic [1:0]    ab_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] snap;
  logic [1:0]    step;
  logic          go_up, go_dn;

  assign step     = phase_of(ab_sync) - phase_of(ab_q);
  assign go_up    = (step == 2'd1);
  assign go_dn    = (step == 2'd3);
  assign bad_step = (step == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q <= '0;
      cnt  <= '0;
    end else begin
      ab_q <= ab_sync;
      if (go_up)      cnt <= cnt + CW'(1);
      else if (go_dn) cnt <= cnt - CW'(1);
    end
  end

  // First fetch (top byte) freezes the count; later fetches use the frozen copy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap    <= '0;
      rd_byte <= '0;
    end else if (rd_stb) begin
      if (rd_idx == IW'(NB-1)) begin
        snap    <= cnt;
        rd_byte <= cnt[(NB-1)*BW +: BW];
      end else begin
        rd_byte <= snap[rd_idx*BW +: BW];
      end
    end
  end

  AST_ILLEGAL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_step |=> $stable(cnt)) else $error("illegal step moved count"); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (CW'(cnt - $past(cnt)) == CW'(1) || CW'($past(cnt) - cnt) == CW'(1)))
    else $error("count jumped by more than one"); // R2
endmodule

// File: rtl/pos_widener.sv
module pos_widener
  import qpos_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8,
  parameter int PW = 32,
  localparam int NB = CW / BW,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int AW = CW - BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          rd_stb,
  output logic [IW-1:0] rd_idx,
  input  logic [BW-1:0] rd_byte,
  output logic          vld,
  input  logic          rdy,
  output logic [PW-1:0] x0,
  output logic [PW-1:0] x1,
  output logic [PW-1:0] x2
);
  fetch_state_e  st;
  logic [IW-1:0] idx;
  logic [AW-1:0] asm_q;
  logic [CW-1:0] reading, prev_rd, delta;

  assign rd_stb  = (st == ST_READ);
  assign rd_idx  = idx;
  assign reading = {asm_q, rd_byte};
  assign delta   = reading - prev_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      asm_q   <= '0;
      prev_rd <= '0;
      vld     <= 1'b0;
      x0      <= '0;
      x1      <= '0;
      x2      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req) begin
          st  <= ST_READ;
          idx <= IW'(NB-1);
        end
        ST_READ: begin
          if (idx != IW'(NB-1)) asm_q <= AW'({asm_q, rd_byte});
          if (idx == '0) st <= ST_CALC;
          else           idx <= idx - IW'(1);
        end
        ST_CALC: begin
          x0      <= x0 + {{(PW-CW){delta[CW-1]}}, delta};
          x1      <= x0;
          x2      <= x1;
          prev_rd <= reading;
          vld     <= 1'b1;
          st      <= ST_HOLD;
        end
        default: if (rdy) begin
          vld <= 1'b0;
          st  <= ST_IDLE;
        end
      endcase
    end
  end

  AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> (x1 == $past(x0) && x2 == $past(x1)))
    else $error("history did not shift"); // R6

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !rdy) |=> (vld && $stable(x0) && $stable(x1) && $stable(x2)))
    else $error("stream moved without ready"); // R7

  AST_NO_FETCH_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> !rd_stb) else $error("fetch started while result pending"); // R8
endmodule

// File: rtl/qpos_extender.sv
module qpos_extender #(
  parameter int CW = 16,
  parameter int BW = 8,
  parameter int PW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          sample_req,
  input  logic          pos_ready,
  output logic          pos_valid,
  output logic [PW-1:0] pos_now,
  output logic [PW-1:0] pos_prev1,
  output logic [PW-1:0] pos_prev2,
  output logic          quad_err
);
  localparam int NB = CW / BW;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [1:0]    ab_s;
  logic          lane_stb;
  logic [IW-1:0] lane_idx;
  logic [BW-1:0] lane_byte;

  sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b}), .q(ab_s)
  );

  quad_counter #(.CW(CW), .BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ab_sync(ab_s),
    .rd_stb(lane_stb), .rd_idx(lane_idx), .rd_byte(lane_byte),
    .bad_step(quad_err)
  );

  pos_widener #(.CW(CW), .BW(BW), .PW(PW)) u_wide (
    .clk(clk), .rst_n(rst_n), .req(sample_req),
    .rd_stb(lane_stb), .rd_idx(lane_idx), .rd_byte(lane_byte),
    .vld(pos_valid), .rdy(pos_ready),
    .x0(pos_now), .x1(pos_prev1), .x2(pos_prev2)
  );

  AST_ERR_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    quad_err |=> !quad_err) else $error("error flag held"); // R3
endmodule

// File: tb/qpos_extender_test.sv
module qpos_extender_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic sample_req = 1'b0;
  logic pos_ready = 1'b1;
  logic pos_valid, quad_err;
  logic [31:0] pos_now, pos_prev1, pos_prev2;

  always #5 clk = ~clk;

  qpos_extender uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .sample_req(sample_req), .pos_ready(pos_ready), .pos_valid(pos_valid),
    .pos_now(pos_now), .pos_prev1(pos_prev1), .pos_prev2(pos_prev2),
    .quad_err(quad_err)
  );

  typedef struct {
    logic [31:0] e0, e1, e2;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   sb_on    = 1'b1;
  bit   err_seen = 1'b0;
  int   ph = 0;
  int   mc = 0;
  int   m0 = 0, m1 = 0, m2 = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // Monitor: one comparison per handshake.
  always @(negedge clk) begin
    if (quad_err) err_seen = 1'b1;
    if (rst_n && sb_on && pos_valid && pos_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 unexpected extra result", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(pos_now   == e.e0, {e.tag, " pos_now"},   $signed(pos_now),   $signed(e.e0));
        check(pos_prev1 == e.e1, {e.tag, " pos_prev1 (R6)"}, $signed(pos_prev1), $signed(e.e1));
        check(pos_prev2 == e.e2, {e.tag, " pos_prev2 (R6)"}, $signed(pos_prev2), $signed(e.e2));
      end
    end
  end

  task automatic step(input int dir);
    ph = (ph + dir) & 3;
    case (ph)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b01;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b10;
    endcase
    mc += dir;
    repeat (2) @(negedge clk);
  endtask

  task automatic move(input int n);
    for (int i = 0; i < (n < 0 ? -n : n); i++) step(n < 0 ? -1 : 1);
  endtask

  task automatic pulse_req();
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
  endtask

  task automatic sample(input string tag);
    exp_t e;
    repeat (5) @(negedge clk);
    wait (sb_q.size() == 0 && !pos_valid);
    @(negedge clk);
    m2 = m1; m1 = m0; m0 = mc;
    e.e0 = m0; e.e1 = m1; e.e2 = m2; e.tag = tag;
    sb_q.push_back(e);
    pulse_req();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pos_valid == 1'b0 && quad_err == 1'b0, "R1 flags after reset", pos_valid, 0);
    check(pos_now == 0 && pos_prev1 == 0 && pos_prev2 == 0, "R1 positions after reset", pos_now, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sample("R1 zero reading");

    // R2: forward and reverse counting
    move(7);
    sample("R2 forward");
    move(-12);
    sample("R2 reverse / R5 wrap below zero");

    // R3: illegal double change
    err_seen = 1'b0;
    ph = (ph + 2) & 3;
    {enc_a, enc_b} = ~{enc_a, enc_b};
    repeat (6) @(negedge clk);
    check(err_seen, "R3 quad_err flagged", err_seen, 1);
    sample("R3 count unchanged");
    err_seen = 1'b0;
    move(3);
    check(!err_seen, "R3 no flag on legal steps", err_seen, 0);

    // R4: coherent fetch while counter rolls 0xFFFF -> 0x0000
    for (int k = 0; k < 8; k++) begin
      int lo, hi;
      move(-6 - mc);
      repeat (6) @(negedge clk);
      sb_on = 1'b0;
      lo = mc;
      hi = mc + 12;
      fork
        move(12);
        begin
          repeat (2 * k + 2) @(negedge clk);
          pulse_req();
          wait (pos_valid);
          @(negedge clk);
          check($signed(pos_now) >= lo && $signed(pos_now) <= hi,
                "R4 coherent snapshot", $signed(pos_now), lo);
          m2 = m1; m1 = m0; m0 = $signed(pos_now);
          @(negedge clk);
        end
      join
      sb_on = 1'b1;
    end
    sample("R4/R5 after roll");

    // R5: wide travel across 0x7FFF and 0xFFFF
    move(20000);
    sample("R5 first leg");
    move(20000);
    sample("R5 past 0x7FFF");
    move(30000);
    sample("R5 past 0xFFFF");
    move(-1000);
    sample("R6 history");

    // R7 / R8: back-pressure and busy requests
    begin
      exp_t e;
      logic [31:0] held;
      move(5);
      repeat (6) @(negedge clk);
      pos_ready = 1'b0;
      m2 = m1; m1 = m0; m0 = mc;
      e.e0 = m0; e.e1 = m1; e.e2 = m2; e.tag = "R7 held result";
      sb_q.push_back(e);
      pulse_req();
      repeat (6) @(negedge clk);
      check(pos_valid, "R7 valid raised", pos_valid, 1);
      held = pos_now;
      move(4);
      pulse_req();
      repeat (6) @(negedge clk);
      check(pos_valid && pos_now == held, "R7 held stable", $signed(pos_now), $signed(held));
      pos_ready = 1'b1;
      repeat (12) @(negedge clk);
      check(sb_q.size() == 0 && !pos_valid, "R8 busy request dropped", pos_valid, 0);
      sample("R8 next sample normal");
    end

    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule